// File: doc/BRIEF.md
# Register Rename Map with Ready Flag

This block records, for every architectural register, which in-flight instruction is the newest to write it. Each entry holds a producer tag, where tag 0 is reserved and means "no producer in flight", and a flag saying the producer's result has already been written to the reorder buffer. Dispatch logic uses the table to decide where each source operand comes from. It can come from the register file, from the reorder buffer, or it must wait for a broadcast carrying the reported tag.

Each cycle the table serves two source lookups and one destination update from the dispatch stage. It also takes a completion report, which sets the ready flag, and a retire report, which removes the mapping. Completion and retire act on an entry only while the entry still names the reporting tag, so results from older writers of a remapped register leave the entry alone. A flush empties the whole table so that execution can restart from the committed register file. Lookups read the state held at the start of the cycle, so an instruction that reads and writes the same register sees its older producer. A completion in the same cycle is forwarded into the lookup result.

Top module: `rmt_map_table`

## Requirements
- R1: After synchronous reset every register looks up with tag 0 and location code 0.
- R2: Location codes are 0 = register file, 1 = not yet produced, 2 = in reorder buffer. A tag of 0 always reports code 0, and a nonzero tag reports code 1 or 2.
- R3: A dispatch with destination register d and tag t makes d look up, from the next cycle on, as tag t with code 1.
- R4: A completion naming register d and tag t, when d holds t, makes d report code 2 from the next cycle on.
- R5: A completion whose tag differs from the tag held by the named register leaves that entry unchanged.
- R6: A retire naming register d and tag t, when d holds t, makes d report tag 0 and code 0 from the next cycle on.
- R7: A retire whose tag differs from the tag held by the named register leaves that entry unchanged.
- R8: A flush clears every entry to tag 0 and code 0 in the next cycle.
- R9: A lookup in the same cycle as a dispatch to the same register returns the mapping held before that dispatch.
- R10: When a dispatch and a retire, or a dispatch and a completion, name the same register in one cycle, the entry takes the dispatched tag with code 1.
- R11: A lookup whose register is named by a matching completion in the same cycle reports code 2.
- R12: A flush in the same cycle as a dispatch wins, and the dispatched register reads tag 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clear all entries |
| disp_valid | input | 1 | Destination update valid |
| disp_dst | input | 5 | Destination register index |
| disp_tag | input | 4 | New producer tag (nonzero) |
| src0_idx | input | 5 | First source register |
| src1_idx | input | 5 | Second source register |
| src0_tag | output | 4 | Producer tag of first source |
| src0_loc | output | 2 | Location code of first source |
| src1_tag | output | 4 | Producer tag of second source |
| src1_loc | output | 2 | Location code of second source |
| cmp_valid | input | 1 | Completion report valid |
| cmp_reg | input | 5 | Register written by completing instruction |
| cmp_tag | input | 4 | Tag of completing instruction |
| ret_valid | input | 1 | Retire report valid |
| ret_reg | input | 5 | Register written by retiring instruction |
| ret_tag | input | 4 | Tag of retiring instruction |

## Verification
The assertions check every entry on every cycle. A flush empties the entry, a dispatch installs its tag with the flag clear, and a matching completion or retire takes effect. A report that does not match leaves the entry stable, a ready flag never sits on tag 0, and a completion that matches a looked-up source is forwarded. Only the bench scenarios can show the visible order of events. These are a lookup returning the old mapping while the same register is being renamed, the priority of a dispatch over a retire or completion of its predecessor, and a flush beating a simultaneous dispatch. They also include the remap-then-stale-report sequences and the reset state seen across the whole register range.

// File: rtl/rmt_pkg.sv
package rmt_pkg;

    typedef enum logic [1:0] {
        LOC_REGFILE = 2'd0,
        LOC_PENDING = 2'd1,
        LOC_ROB     = 2'd2
    } src_loc_e;

    // Map the entry state (plus a same-cycle completion hit) to a location.
    function automatic src_loc_e classify(input logic has_tag,
                                          input logic ready,
                                          input logic fwd_hit);
        src_loc_e loc;
        if (!has_tag)
            loc = LOC_REGFILE;
        else if (ready || fwd_hit)
            loc = LOC_ROB;
        else
            loc = LOC_PENDING;
        return loc;
    endfunction

endpackage

// File: rtl/rmt_entry.sv
module rmt_entry #(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             cmp_en,
    input  logic [TAG_W-1:0] cmp_tag,
    input  logic             ret_en,
    input  logic [TAG_W-1:0] ret_tag,
    output logic [TAG_W-1:0] tag_q,
    output logic             rdy_q
);

    logic cmp_hit;
    logic ret_hit;

    assign cmp_hit = cmp_en && (cmp_tag == tag_q) && (tag_q != '0);
    assign ret_hit = ret_en && (ret_tag == tag_q);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            tag_q <= '0;
            rdy_q <= 1'b0;
        end else if (wr_en) begin
            tag_q <= wr_tag;
            rdy_q <= 1'b0;
        end else if (ret_hit) begin
            tag_q <= '0;
            rdy_q <= 1'b0;
        end else if (cmp_hit) begin
            rdy_q <= 1'b1;
        end
    end

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (tag_q == '0 && !rdy_q)); // R8

    AST_DISPATCH_TAKES: assert property (@(posedge clk) disable iff (rst)
        (!flush && wr_en) |=> (tag_q == $past(wr_tag) && !rdy_q)); // R3

    AST_CMP_SETS: assert property (@(posedge clk) disable iff (rst)
        (!flush && !wr_en && !ret_en && cmp_en && cmp_tag == tag_q && tag_q != '0)
        |=> rdy_q); // R4

    AST_RET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!flush && !wr_en && ret_en && ret_tag == tag_q) |=> (tag_q == '0)); // R6

    AST_STALE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!flush && !wr_en && !(cmp_en && cmp_tag == tag_q) && !(ret_en && ret_tag == tag_q))
        |=> ($stable(tag_q) && $stable(rdy_q))); // R5 R7

    AST_READY_NEEDS_TAG: assert property (@(posedge clk) disable iff (rst)
        rdy_q |-> (tag_q != '0)); // R2

endmodule

// File: rtl/rmt_lookup.sv
module rmt_lookup #(
    parameter int NUM_REGS = 32,
    parameter int TAG_W    = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_REGS-1:0][TAG_W-1:0]  tags,
    input  logic [NUM_REGS-1:0]             rdys,
    input  logic [IDX_W-1:0]                idx,
    input  logic                            cmp_valid,
    input  logic [IDX_W-1:0]                cmp_reg,
    input  logic [TAG_W-1:0]                cmp_tag,
    output logic [TAG_W-1:0]                tag_out,
    output logic [1:0]                      loc_out
);
    import rmt_pkg::*;

    logic [TAG_W-1:0] cur_tag;
    logic             cur_rdy;
    logic             fwd_hit;
    src_loc_e         loc;

    assign cur_tag = tags[idx];
    assign cur_rdy = rdys[idx];
    assign fwd_hit = cmp_valid && (cmp_reg == idx) && (cmp_tag == cur_tag);

    always_comb begin
        loc = classify(cur_tag != '0, cur_rdy, fwd_hit);
    end

    assign tag_out = cur_tag;
    assign loc_out = loc;

    AST_BYPASS_READY: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_reg == idx && cmp_tag == tag_out && tag_out != '0)
        |-> (loc_out == 2'd2)); // R11

    AST_ZERO_IS_REGFILE: assert property (@(posedge clk) disable iff (rst)
        (tag_out == '0) |-> (loc_out == 2'd0)); // R2

    AST_LOC_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (tag_out != '0) |-> (loc_out == 2'd1 || loc_out == 2'd2)); // R2

endmodule

// File: rtl/rmt_map_table.sv
module rmt_map_table #(
    parameter int NUM_REGS = 32,
    parameter int TAG_W    = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             disp_valid,
    input  logic [IDX_W-1:0] disp_dst,
    input  logic [TAG_W-1:0] disp_tag,
    input  logic [IDX_W-1:0] src0_idx,
    input  logic [IDX_W-1:0] src1_idx,
    output logic [TAG_W-1:0] src0_tag,
    output logic [1:0]       src0_loc,
    output logic [TAG_W-1:0] src1_tag,
    output logic [1:0]       src1_loc,
    input  logic             cmp_valid,
    input  logic [IDX_W-1:0] cmp_reg,
    input  logic [TAG_W-1:0] cmp_tag,
    input  logic             ret_valid,
    input  logic [IDX_W-1:0] ret_reg,
    input  logic [TAG_W-1:0] ret_tag
);

    localparam int NUM_SRC = 2;

    logic [NUM_REGS-1:0]            wr_sel;
    logic [NUM_REGS-1:0]            cmp_sel;
    logic [NUM_REGS-1:0]            ret_sel;
    logic [NUM_REGS-1:0][TAG_W-1:0] tag_arr;
    logic [NUM_REGS-1:0]            rdy_arr;

    logic [NUM_SRC-1:0][IDX_W-1:0]  src_idx;
    logic [NUM_SRC-1:0][TAG_W-1:0]  src_tag;
    logic [NUM_SRC-1:0][1:0]        src_loc;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
        assign wr_sel[i]  = disp_valid && (disp_dst == IDX_W'(i));
        assign cmp_sel[i] = cmp_valid  && (cmp_reg  == IDX_W'(i));
        assign ret_sel[i] = ret_valid  && (ret_reg  == IDX_W'(i));

        rmt_entry #(.TAG_W(TAG_W)) u_entry (
            .clk     (clk),
            .rst     (rst),
            .flush   (flush),
            .wr_en   (wr_sel[i]),
            .wr_tag  (disp_tag),
            .cmp_en  (cmp_sel[i]),
            .cmp_tag (cmp_tag),
            .ret_en  (ret_sel[i]),
            .ret_tag (ret_tag),
            .tag_q   (tag_arr[i]),
            .rdy_q   (rdy_arr[i])
        );
    end

    assign src_idx[0] = src0_idx;
    assign src_idx[1] = src1_idx;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        rmt_lookup #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_lookup (
            .clk       (clk),
            .rst       (rst),
            .tags      (tag_arr),
            .rdys      (rdy_arr),
            .idx       (src_idx[s]),
            .cmp_valid (cmp_valid),
            .cmp_reg   (cmp_reg),
            .cmp_tag   (cmp_tag),
            .tag_out   (src_tag[s]),
            .loc_out   (src_loc[s])
        );
    end

    assign src0_tag = src_tag[0];
    assign src0_loc = src_loc[0];
    assign src1_tag = src_tag[1];
    assign src1_loc = src_loc[1];

    AST_DISPATCH_OVER_RETIRE: assert property (@(posedge clk) disable iff (rst)
        (!flush && disp_valid && ret_valid && disp_dst == ret_reg && src0_idx == disp_dst)
        |=> (src0_tag == $past(disp_tag) || src0_idx != $past(disp_dst))); // R10

endmodule

// File: tb/sim_rmt_map_table.sv
module sim_rmt_map_table;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flush = 1'b0;
    logic       disp_valid = 1'b0;
    logic [4:0] disp_dst = '0;
    logic [3:0] disp_tag = '0;
    logic [4:0] src0_idx = '0;
    logic [4:0] src1_idx = '0;
    logic [3:0] src0_tag;
    logic [1:0] src0_loc;
    logic [3:0] src1_tag;
    logic [1:0] src1_loc;
    logic       cmp_valid = 1'b0;
    logic [4:0] cmp_reg = '0;
    logic [3:0] cmp_tag = '0;
    logic       ret_valid = 1'b0;
    logic [4:0] ret_reg = '0;
    logic [3:0] ret_tag = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    rmt_map_table u0 (
        .clk(clk), .rst(rst), .flush(flush),
        .disp_valid(disp_valid), .disp_dst(disp_dst), .disp_tag(disp_tag),
        .src0_idx(src0_idx), .src1_idx(src1_idx),
        .src0_tag(src0_tag), .src0_loc(src0_loc),
        .src1_tag(src1_tag), .src1_loc(src1_loc),
        .cmp_valid(cmp_valid), .cmp_reg(cmp_reg), .cmp_tag(cmp_tag),
        .ret_valid(ret_valid), .ret_reg(ret_reg), .ret_tag(ret_tag)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       dv;  logic [4:0] dd; logic [3:0] dt;
        logic       cv;  logic [4:0] cr; logic [3:0] ct;
        logic       rv;  logic [4:0] rr; logic [3:0] rt;
        logic       fl;
        logic [4:0] s0;  logic [4:0] s1;
        logic [3:0] e0t; logic [1:0] e0l;
        logic [3:0] e1t; logic [1:0] e1l;
    } vec_t;

    localparam int NV = 19;
    // Inputs are applied for one cycle; expected lookups are what the
    // ports show during that cycle (state from earlier vectors).
    localparam vec_t VEC [NV] = '{
        // R9: dispatch r1<-1 while reading r1: old mapping (empty)
        '{4'd9,  1'b1,5'd1,4'd1,   1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b0, 5'd1,5'd2,   4'd0,2'd0, 4'd0,2'd0},
        // R3 / R9: r1 pending on tag 1; dispatch r2<-2 while reading r2
        '{4'd3,  1'b1,5'd2,4'd2,   1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b0, 5'd1,5'd2,   4'd1,2'd1, 4'd0,2'd0},
        // R11: completion r1/tag1 forwarded into lookup
        '{4'd11, 1'b0,5'd0,4'd0,   1'b1,5'd1,4'd1,   1'b0,5'd0,4'd0,   1'b0, 5'd1,5'd2,   4'd1,2'd2, 4'd2,2'd1},
        // R4: r1 now ready in ROB; remap r1<-5 in same cycle reads old
        '{4'd4,  1'b1,5'd1,4'd5,   1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b0, 5'd1,5'd2,   4'd1,2'd2, 4'd2,2'd1},
        // R5: stale completion r1/tag1 while r1 holds 5
        '{4'd5,  1'b0,5'd0,4'd0,   1'b1,5'd1,4'd1,   1'b0,5'd0,4'd0,   1'b0, 5'd1,5'd2,   4'd5,2'd1, 4'd2,2'd1},
        // R7: stale retire r1/tag1
        '{4'd7,  1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b1,5'd1,4'd1,   1'b0, 5'd1,5'd2,   4'd5,2'd1, 4'd2,2'd1},
        // R5 / R7: r1 still tag 5 pending afterwards
        '{4'd5,  1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b0, 5'd1,5'd3,   4'd5,2'd1, 4'd0,2'd0},
        // R11: completion r2/tag2 forwarded
        '{4'd11, 1'b0,5'd0,4'd0,   1'b1,5'd2,4'd2,   1'b0,5'd0,4'd0,   1'b0, 5'd2,5'd1,   4'd2,2'd2, 4'd5,2'd1},
        // R6: retire r2/tag2; lookup still sees ROB this cycle
        '{4'd6,  1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b1,5'd2,4'd2,   1'b0, 5'd2,5'd1,   4'd2,2'd2, 4'd5,2'd1},
        // R6: r2 back in register file
        '{4'd6,  1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b0, 5'd2,5'd1,   4'd0,2'd0, 4'd5,2'd1},
        // R10: dispatch r1<-6 and retire r1/tag5 together
        '{4'd10, 1'b1,5'd1,4'd6,   1'b0,5'd0,4'd0,   1'b1,5'd1,4'd5,   1'b0, 5'd1,5'd4,   4'd5,2'd1, 4'd0,2'd0},
        // R10: dispatch r1<-8 and completion r1/tag6 together
        '{4'd10, 1'b1,5'd1,4'd8,   1'b1,5'd1,4'd6,   1'b0,5'd0,4'd0,   1'b0, 5'd1,5'd4,   4'd6,2'd2, 4'd0,2'd0},
        // R10: r1 holds 8, not ready
        '{4'd10, 1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b0, 5'd1,5'd2,   4'd8,2'd1, 4'd0,2'd0},
        // R3: dispatch r2<-9
        '{4'd3,  1'b1,5'd2,4'd9,   1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b0, 5'd1,5'd2,   4'd8,2'd1, 4'd0,2'd0},
        // R12: flush together with dispatch r4<-3
        '{4'd12, 1'b1,5'd4,4'd3,   1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b1, 5'd1,5'd2,   4'd8,2'd1, 4'd9,2'd1},
        // R8 / R12: everything cleared, r4 not written
        '{4'd8,  1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b0, 5'd1,5'd4,   4'd0,2'd0, 4'd0,2'd0},
        // R3: top register r31 takes largest tag 15
        '{4'd3,  1'b1,5'd31,4'd15, 1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b0, 5'd31,5'd2,  4'd0,2'd0, 4'd0,2'd0},
        // R11: completion r31/tag15 forwarded
        '{4'd11, 1'b0,5'd0,4'd0,   1'b1,5'd31,4'd15, 1'b0,5'd0,4'd0,   1'b0, 5'd31,5'd31, 4'd15,2'd2, 4'd15,2'd2},
        // R4: r31 ready held in the table
        '{4'd4,  1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b0,5'd0,4'd0,   1'b0, 5'd0,5'd31,  4'd0,2'd0, 4'd15,2'd2}
    };

    task automatic check(input int req, input string what,
                         input logic [3:0] gt, input logic [1:0] gl,
                         input logic [3:0] et, input logic [1:0] el);
        checks++;
        if (gt !== et || gl !== el) begin
            fails++;
            $display("FAIL R%0d %s: got tag %0d loc %0d, expected tag %0d loc %0d",
                     req, what, gt, gl, et, el);
        end
    endtask

    task automatic idle_inputs();
        disp_valid = 1'b0; cmp_valid = 1'b0; ret_valid = 1'b0; flush = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: every register empty after reset
        for (int r = 0; r < 32; r += 2) begin
            src0_idx = 5'(r);
            src1_idx = 5'(r + 1);
            #1;
            check(1, "reset state src0", src0_tag, src0_loc, 4'd0, 2'd0);
            check(1, "reset state src1", src1_tag, src1_loc, 4'd0, 2'd0);
        end

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            disp_valid = VEC[v].dv; disp_dst = VEC[v].dd; disp_tag = VEC[v].dt;
            cmp_valid  = VEC[v].cv; cmp_reg  = VEC[v].cr; cmp_tag  = VEC[v].ct;
            ret_valid  = VEC[v].rv; ret_reg  = VEC[v].rr; ret_tag  = VEC[v].rt;
            flush      = VEC[v].fl;
            src0_idx   = VEC[v].s0; src1_idx = VEC[v].s1;
            #1;
            check(int'(VEC[v].req), $sformatf("vector %0d src0", v),
                  src0_tag, src0_loc, VEC[v].e0t, VEC[v].e0l);
            check(int'(VEC[v].req), $sformatf("vector %0d src1", v),
                  src1_tag, src1_loc, VEC[v].e1t, VEC[v].e1l);
        end

        // R1: reset in mid-run clears a live mapping
        @(negedge clk);
        idle_inputs();
        disp_valid = 1'b1; disp_dst = 5'd5; disp_tag = 4'd4;
        @(negedge clk);
        idle_inputs();
        src0_idx = 5'd5; src1_idx = 5'd31;
        #1;
        check(3, "r5 mapped before reset", src0_tag, src0_loc, 4'd4, 2'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(1, "r5 after mid-run reset", src0_tag, src0_loc, 4'd0, 2'd0);
        check(1, "r31 after mid-run reset", src1_tag, src1_loc, 4'd0, 2'd0);

        // R9: both sources name the renamed register in the same cycle
        @(negedge clk);
        disp_valid = 1'b1; disp_dst = 5'd7; disp_tag = 4'd3;
        src0_idx = 5'd7; src1_idx = 5'd7;
        #1;
        check(9, "src0 old mapping", src0_tag, src0_loc, 4'd0, 2'd0);
        check(9, "src1 old mapping", src1_tag, src1_loc, 4'd0, 2'd0);
        @(negedge clk);
        idle_inputs();
        #1;
        check(3, "r7 new mapping", src0_tag, src0_loc, 4'd3, 2'd1);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule